// File: doc/BRIEF.md
# Windowed Output Router for One I/O Block

This block steers sixteen macrocell results onto eight I/O cells. Each I/O cell owns a routing slice. The slice picks one macrocell from an eight-wide window whose start advances by two macrocells per cell and wraps modulo sixteen. The output-enable term of the chosen macrocell travels with its data, so moving an output to another pin also moves its enable. A bypass stage in each slice can instead drive the pin from the cell's home macrocell (macrocell 2n), or from a per-cell fast-path signal in true or inverted form.

Routing is set by a 40-bit configuration word. The word is shifted in serially and then committed in one step, so the routing never sees a half-loaded word. Data and enable paths are purely combinational. Only the configuration is registered.

Top module: `orp_router`

## Requirements
- R1: After a synchronous active-low reset the committed configuration is all zeros, so io_data[n] = mc_data[2n] and io_oe[n] = mc_oe[2n] for every cell n.
- R2: In routed mode (mode 2'b00), io_data[n] = mc_data[(2n + sel) mod 16], where sel is the cell's 3-bit window select.
- R3: In routed mode, io_oe[n] = mc_oe[(2n + sel) mod 16], using the same select as the data.
- R4: In direct mode (mode 2'b01), io_data[n] = mc_data[2n] whatever the value of sel.
- R5: In fast-true mode (mode 2'b10), io_data[n] = fp_in[n].
- R6: In fast-inverted mode (mode 2'b11), io_data[n] = ~fp_in[n].
- R7: In any bypass mode (mode not 2'b00), io_oe[n] = mc_oe[2n] whatever the value of sel.
- R8: Shifting configuration bits without a commit pulse leaves io_data and io_oe unchanged in their dependence on the inputs.
- R9: The word is shifted MSB first on cfg_din while cfg_shift is high. Cell n uses bits [5n+4:5n], laid out as {mode[1:0], sel[2:0]}.
- R10: On a clock edge with cfg_load high, the committed word takes the value the shift register held before that edge, even if a shift happens on the same edge. Outputs follow from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shift | input | 1 | Shift enable for the serial configuration |
| cfg_din | input | 1 | Serial configuration bit, MSB first |
| cfg_load | input | 1 | One-cycle commit of the shifted word |
| mc_data | input | 16 | Macrocell data outputs |
| mc_oe | input | 16 | Per-macrocell output-enable terms |
| fp_in | input | 8 | Per-cell fast-path signal |
| io_data | output | 8 | Data bit to each I/O cell |
| io_oe | output | 8 | Output enable to each I/O cell |

## Verification
The bench uses the default sizes: sixteen macrocells, eight cells, a window of eight and a stride of two. With these sizes the windows of cells five to seven wrap past macrocell fifteen, so the modulo arithmetic is exercised for real. Directed words sweep every select value and every bypass mode across all cells. Random words and random inputs each clock then mix modes between neighbouring cells. A commit that coincides with the last shift checks the pre-edge capture.

// File: rtl/orp_pkg.sv
// Package: shared encodings for the output router.
// Assumes: two-bit bypass field, decoded identically by every slice.
package orp_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        BYP_ROUTED = 2'b00,
        BYP_DIRECT = 2'b01,
        BYP_FAST_T = 2'b10,
        BYP_FAST_N = 2'b11
    } byp_mode_e;
endpackage

// File: rtl/orp_cfg_regs.sv
// Module: serial configuration shifter plus committed copy.
// Assumes: shift and load may coincide; load captures the pre-edge shifter.
module orp_cfg_regs #(
    parameter int CFG_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    input  logic             load,
    output logic [CFG_W-1:0] sh_q,
    output logic [CFG_W-1:0] act_q
);
    // Shift register: new bit enters at the LSB, so the first bit ends at the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (shift_en) begin
            sh_q <= {sh_q[CFG_W-2:0], din};
        end
    end

    // Committed word: copied whole on a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (load) begin
            act_q <= sh_q;
        end
    end
endmodule

// File: rtl/orp_slice.sv
// Module: one routing slice (window mux, enable mux, bypass mux).
// Assumes: window bit 0 is the cell's home macrocell; WIN is a power of two.
module orp_slice
    import orp_pkg::*;
#(
    parameter int WIN   = 8,
    parameter int SEL_W = $clog2(WIN)
) (
    input  logic [WIN-1:0]   win_d,
    input  logic [WIN-1:0]   win_oe,
    input  logic             fp,
    input  logic [SEL_W-1:0] sel,
    input  byp_mode_e        mode,
    output logic             io_d,
    output logic             io_en
);
    logic routed_d;
    logic routed_oe;

    // Window pick: data and enable share one select.
    always_comb begin
        routed_d  = win_d[sel];
        routed_oe = win_oe[sel];
    end

    // Bypass stage: choose the pin source and its enable.
    always_comb begin
        io_en = win_oe[0];
        unique case (mode)
            BYP_ROUTED: begin
                io_d  = routed_d;
                io_en = routed_oe;
            end
            BYP_DIRECT: io_d = win_d[0];
            BYP_FAST_T: io_d = fp;
            BYP_FAST_N: io_d = ~fp;
            default:    io_d = routed_d;
        endcase
    end
endmodule

// File: rtl/orp_router.sv
// Module: output router top; builds one slice per I/O cell.
// Assumes: cell n's window starts at macrocell (STRIDE*n) mod NUM_MC.
module orp_router
    import orp_pkg::*;
#(
    parameter int NUM_MC = 16,
    parameter int NUM_IO = 8,
    parameter int WIN    = 8,
    parameter int STRIDE = 2
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic              cfg_shift,
    input  logic              cfg_din,
    input  logic              cfg_load,
    input  logic [NUM_MC-1:0] mc_data,
    input  logic [NUM_MC-1:0] mc_oe,
    input  logic [NUM_IO-1:0] fp_in,
    output logic [NUM_IO-1:0] io_data,
    output logic [NUM_IO-1:0] io_oe
);
    localparam int SEL_W   = $clog2(WIN);
    localparam int SLICE_W = SEL_W + MODE_W;
    localparam int CFG_W   = SLICE_W * NUM_IO;

    logic [CFG_W-1:0] cfg_sh;
    logic [CFG_W-1:0] cfg_act;

    orp_cfg_regs #(.CFG_W(CFG_W)) u_cfg (
        .clk      (cfg_clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift),
        .din      (cfg_din),
        .load     (cfg_load),
        .sh_q     (cfg_sh),
        .act_q    (cfg_act)
    );

    for (genvar n = 0; n < NUM_IO; n++) begin : g_cell
        localparam int BASE = (STRIDE * n) % NUM_MC;
        logic [WIN-1:0] win_d;
        logic [WIN-1:0] win_oe;

        for (genvar k = 0; k < WIN; k++) begin : g_win
            assign win_d[k]  = mc_data[(BASE + k) % NUM_MC];
            assign win_oe[k] = mc_oe[(BASE + k) % NUM_MC];
        end

        orp_slice #(.WIN(WIN), .SEL_W(SEL_W)) u_slice (
            .win_d  (win_d),
            .win_oe (win_oe),
            .fp     (fp_in[n]),
            .sel    (cfg_act[n*SLICE_W +: SEL_W]),
            .mode   (byp_mode_e'(cfg_act[n*SLICE_W + SEL_W +: MODE_W])),
            .io_d   (io_data[n]),
            .io_en  (io_oe[n])
        );
    end
endmodule

// File: rtl/orp_router_chk.sv
// Module: property checker for orp_router, attached by bind below.
// Assumes: all relations are sampled on the configuration clock.
module orp_router_chk #(
    parameter int NUM_MC = 16,
    parameter int NUM_IO = 8,
    parameter int WIN    = 8,
    parameter int STRIDE = 2,
    parameter int CFG_W  = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic [CFG_W-1:0]  cfg_sh,
    input logic [CFG_W-1:0]  cfg_act,
    input logic [NUM_MC-1:0] mc_data,
    input logic [NUM_MC-1:0] mc_oe,
    input logic [NUM_IO-1:0] fp_in,
    input logic [NUM_IO-1:0] io_data,
    input logic [NUM_IO-1:0] io_oe
);
    localparam int SEL_W   = $clog2(WIN);
    localparam int SLICE_W = SEL_W + 2;

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_act == '0);

    a_r8_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(cfg_act));

    a_r10_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> cfg_act == $past(cfg_sh));

    for (genvar n = 0; n < NUM_IO; n++) begin : g_chk
        localparam int HOME = (STRIDE * n) % NUM_MC;
        logic [SEL_W-1:0] sel;
        logic [1:0]       md;
        int               ridx;

        assign sel  = cfg_act[n*SLICE_W +: SEL_W];
        assign md   = cfg_act[n*SLICE_W + SEL_W +: 2];
        assign ridx = (STRIDE * n + int'(sel)) % NUM_MC;

        a_r2_routed_data: assert property (@(posedge clk) disable iff (!rst_n)
            md == 2'b00 |-> io_data[n] == mc_data[ridx]);

        a_r3_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
            md == 2'b00 |-> io_oe[n] == mc_oe[ridx]);

        a_r6_fast_inverted: assert property (@(posedge clk) disable iff (!rst_n)
            md == 2'b11 |-> io_data[n] == !fp_in[n]);

        a_r7_bypass_oe: assert property (@(posedge clk) disable iff (!rst_n)
            md != 2'b00 |-> io_oe[n] == mc_oe[HOME]);
    end
endmodule

bind orp_router orp_router_chk #(
    .NUM_MC (NUM_MC),
    .NUM_IO (NUM_IO),
    .WIN    (WIN),
    .STRIDE (STRIDE),
    .CFG_W  (CFG_W)
) u_chk (
    .clk      (cfg_clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_sh   (cfg_sh),
    .cfg_act  (cfg_act),
    .mc_data  (mc_data),
    .mc_oe    (mc_oe),
    .fp_in    (fp_in),
    .io_data  (io_data),
    .io_oe    (io_oe)
);

// File: tb/test_orp_router.sv
// Bench: behavioural model (bit queue + integer window maths) checked every clock.
module test_orp_router;
    localparam int NMC = 16, NIO = 8, STR = 2, SW = 3, SLW = 5, CW = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_shift = 1'b0, cfg_din = 1'b0, cfg_load = 1'b0;
    logic [NMC-1:0] mc_data = '0, mc_oe = '0;
    logic [NIO-1:0] fp_in = '0;
    logic [NIO-1:0] io_data, io_oe;

    int    checks = 0, errors = 0;
    string phase  = "R1";
    bit    cmp_en = 1'b0;
    bit    bitq[$];
    logic [CW-1:0] m_act = '0;

    orp_router i_orp_router (
        .cfg_clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .cfg_load(cfg_load), .mc_data(mc_data), .mc_oe(mc_oe), .fp_in(fp_in),
        .io_data(io_data), .io_oe(io_oe)
    );

    always #5 clk = ~clk;

    // Model of the configuration path: bits queued, committed word rebuilt on load.
    always @(posedge clk) begin
        if (!rst_n) begin
            bitq.delete();
            m_act = '0;
        end else begin
            if (cfg_load) begin
                logic [CW-1:0] v;
                v = '0;
                foreach (bitq[i]) v = {v[CW-2:0], bitq[i]};
                m_act = v;
            end
            if (cfg_shift) begin
                bitq.push_back(cfg_din);
                if (bitq.size() > CW) void'(bitq.pop_front());
            end
        end
    end

    task automatic chk(string tag, int n, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cell %0d got %b exp %b", tag, n, got, exp);
        end
    endtask

    // Per-clock comparison of every cell against the window formula.
    always @(negedge clk) begin
        if (cmp_en) begin
            for (int n = 0; n < NIO; n++) begin
                int sel, md, home, r;
                logic ed, eo;
                string t;
                sel  = int'(m_act[n*SLW +: SW]);
                md   = int'(m_act[n*SLW + SW +: 2]);
                home = (STR * n) % NMC;
                r    = (STR * n + sel) % NMC;
                case (md)
                    0:       begin ed = mc_data[r];  t = "R2"; end
                    1:       begin ed = mc_data[home]; t = "R4"; end
                    2:       begin ed = fp_in[n];    t = "R5"; end
                    default: begin ed = ~fp_in[n];   t = "R6"; end
                endcase
                eo = (md == 0) ? mc_oe[r] : mc_oe[home];
                chk({phase, "/", t, " data"}, n, io_data[n], ed);
                chk({phase, "/", (md == 0) ? "R3" : "R7", " oe"}, n, io_oe[n], eo);
            end
        end
    end

    task automatic rnd_inputs();
        mc_data = 16'($urandom);
        mc_oe   = 16'($urandom);
        fp_in   = 8'($urandom);
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            rnd_inputs();
        end
    endtask

    // Shift a word MSB first (R9); optionally commit after, or on the last shift (R10).
    task automatic send(logic [CW-1:0] w, bit commit_after, bit commit_overlap);
        for (int i = CW - 1; i >= 0; i--) begin
            @(posedge clk); #1;
            cfg_shift = 1'b1;
            cfg_din   = w[i];
            cfg_load  = (i == 0) && commit_overlap;
            rnd_inputs();
        end
        @(posedge clk); #1;
        cfg_shift = 1'b0;
        cfg_load  = commit_after;
        rnd_inputs();
        @(posedge clk); #1;
        cfg_load = 1'b0;
        rnd_inputs();
    endtask

    function automatic logic [CW-1:0] uniform(int sel, int md);
        logic [CW-1:0] w;
        w = '0;
        for (int n = 0; n < NIO; n++) w[n*SLW +: SLW] = {2'(md), 3'(sel)};
        return w;
    endfunction

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [CW-1:0] w;
        rnd_inputs();
        @(posedge clk); #1;
        cmp_en = 1'b1;            // R1: reset state compared while held and after
        idle(3);
        rst_n = 1'b1;
        idle(6);

        phase = "R2";             // every select value in routed mode
        for (int s = 0; s < 8; s++) begin
            send(uniform(s, 0), 1'b1, 1'b0);
            idle(4);
        end

        phase = "R7";             // every bypass mode with nonzero select
        for (int m = 1; m < 4; m++) begin
            send(uniform(5, m), 1'b1, 1'b0);
            idle(4);
        end

        phase = "R9";             // layout: only cell 3 in fast-true, others routed sel 7
        w = uniform(7, 0);
        w[3*SLW +: SLW] = {2'b10, 3'b000};
        send(w, 1'b1, 1'b0);
        @(posedge clk); #1;
        fp_in = 8'h08; mc_data = '0;
        @(negedge clk);
        chk("R9 explicit fast bit", 3, io_data[3], 1'b1);
        chk("R9 explicit neighbour", 2, io_data[2], 1'b0);

        phase = "R8";             // shift a new word without commit
        send(uniform(3, 3), 1'b0, 1'b0);
        idle(4);

        phase = "R10";            // commit coinciding with the last shift
        send(uniform(6, 0), 1'b0, 1'b1);
        idle(4);

        phase = "RND";            // random words, mixed modes per cell
        for (int j = 0; j < 30; j++) begin
            w = {$urandom, $urandom};
            send(w, 1'b1, (j % 5) == 4);
            idle(3);
        end

        phase = "R1";             // reset again clears routing
        @(posedge clk); #1;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(4);
        finish_up();
    end
endmodule